// File: doc/BRIEF.md
# Dual-Channel Compare-Match Timer

Two free-running 32-bit up-counters sit behind a small word-addressed register bus, each paired with a compare register and its own interrupt line. Software presets a counter or reads it back, arms an event by writing `compare = count + delta`, and receives an interrupt request when the counter steps onto the compare value. Counting uses modulo 2^32 arithmetic, so a compare value numerically below the current count is reached after the counter wraps.

A single shared control word holds one enable bit per channel in its low bits and the read-only pending flags from bit 16 upward. There is no separate clear register. A write to a channel's compare register acknowledges that channel. Writing the current count back into the compare register is the normal acknowledge, and it does not re-raise the request, because a match is an event: the counter moving from compare-1 to compare.

Each channel is a two-state machine. In `CH_IDLE`, the transition **hit** (counter steps onto compare while the channel is enabled, with no compare write in the same cycle) leads to `CH_PENDING`. In `CH_PENDING`, the transition **ack** (any write to that channel's compare register) leads back to `CH_IDLE`. An ack in `CH_IDLE` stays in `CH_IDLE`.

Top module: `cmp_timer_pair`

## Requirements
- R1: Byte addresses are 0x00 control, 0x04 compare0, 0x08 count0, 0x0C compare1, 0x10 count1. Any other address, including any with address bits [1:0] nonzero, reads as zero and ignores writes.
- R2: Control bit n (n = 0, 1) is the channel-n enable and is read/write. Bit 16+n is the channel-n pending flag and is read-only. All other control bits read as zero.
- R3: Each counter increments by one on every clock, whatever its enable, and wraps from 0xFFFFFFFF to 0.
- R4: A write to a count register loads the written value in place of that cycle's increment. The next clock resumes counting from it.
- R5: Pending is set on the clock edge at which an enabled channel's counter steps from compare-1 to compare. Loading the count equal to compare sets nothing. With compare 0xFFFFFFFF and count starting from 0, no match occurs within the first few hundred cycles.
- R6: A compare value below the current count is matched after the counter wraps, with delta = compare - count taken modulo 2^32.
- R7: A compare write clears that channel's pending flag on the same edge and wins over a match in that cycle. Writing the current count as compare does not re-raise pending.
- R8: Each interrupt output is high exactly when that channel is pending and enabled. Clearing the enable masks the output but leaves the pending flag set. A disabled channel never becomes pending.
- R9: Reset clears both counts, the enables, the pending flags and the interrupts, and sets both compares to 0xFFFFFFFF.
- R10: The two channels are independent. Activity on one never changes the other's pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; counters step on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write qualifier for the access |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 2 | Interrupt request per channel |

## Verification
The assertions assume that the bus is driven at most once per cycle and that `bus_sel` and `bus_we` are never unknown out of reset. They also assume that software treats the pending bits as status only. The bench drives each write as a single-cycle strobe placed between clock edges and reads combinationally mid-cycle. Every armed delta is at least two, so the compare write lands before the counter can step onto the new value, and the stimulus never depends on a same-edge race between a write and a match.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
    localparam int TMR_NCH      = 2;
    localparam int TMR_PEND_LSB = 16;

    typedef enum logic {
        CH_IDLE    = 1'b0,
        CH_PENDING = 1'b1
    } ch_state_e;
endpackage

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan
    import cmp_timer_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         cnt_wr_i,
    input  logic         cmp_wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] cmp_o,
    output logic         pend_o,
    output logic         irq_o
);
    localparam logic [W-1:0] CMP_RST = {W{1'b1}};

    logic [W-1:0] cnt_q, cmp_q, cnt_inc;
    logic         hit;
    ch_state_e    state_q, state_d;

    assign cnt_inc = cnt_q + W'(1);
    // a hit is the step onto compare, never a standing equality
    assign hit     = !cnt_wr_i && (cnt_inc == cmp_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cmp_q <= CMP_RST;
        end else begin
            cnt_q <= cnt_wr_i ? wdata_i : cnt_inc;
            if (cmp_wr_i) cmp_q <= wdata_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE:    if (!cmp_wr_i && hit && en_i) state_d = CH_PENDING;
            CH_PENDING: if (cmp_wr_i) state_d = CH_IDLE;
            default:    state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pend_o = (state_q == CH_PENDING);
        irq_o  = pend_o && en_i;
    end

    assign cnt_o = cnt_q;
    assign cmp_o = cmp_q;
endmodule

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs #(
    parameter int W        = 32,
    parameter int ADDR_W   = 5,
    parameter int NCH      = 2,
    parameter int PEND_LSB = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel_i,
    input  logic                  we_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [W-1:0]          wdata_i,
    input  logic [NCH-1:0][W-1:0] cnt_i,
    input  logic [NCH-1:0][W-1:0] cmp_i,
    input  logic [NCH-1:0]        pend_i,
    output logic [NCH-1:0]        en_o,
    output logic [NCH-1:0]        cnt_wr_o,
    output logic [NCH-1:0]        cmp_wr_o,
    output logic [W-1:0]          rdata_o
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] widx;
    logic             aligned, wr_go, ctl_wr;
    logic [NCH-1:0]   en_q;

    assign widx    = addr_i[ADDR_W-1:2];
    assign aligned = (addr_i[1:0] == 2'b00);
    assign wr_go   = sel_i && we_i && aligned;
    assign ctl_wr  = wr_go && (widx == '0);

    always_comb begin
        cnt_wr_o = '0;
        cmp_wr_o = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            cmp_wr_o[ch] = wr_go && (widx == IDX_W'(1 + 2*ch));
            cnt_wr_o[ch] = wr_go && (widx == IDX_W'(2 + 2*ch));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      en_q <= '0;
        else if (ctl_wr) en_q <= wdata_i[NCH-1:0];
    end

    always_comb begin
        rdata_o = '0;
        if (aligned) begin
            if (widx == '0) begin
                rdata_o[NCH-1:0]         = en_q;
                rdata_o[PEND_LSB +: NCH] = pend_i;
            end
            for (int ch = 0; ch < NCH; ch++) begin
                if (widx == IDX_W'(1 + 2*ch)) rdata_o = cmp_i[ch];
                if (widx == IDX_W'(2 + 2*ch)) rdata_o = cnt_i[ch];
            end
        end
    end

    assign en_o = en_q;
endmodule

// File: rtl/cmp_timer_pair.sv
module cmp_timer_pair
    import cmp_timer_pkg::*;
#(
    parameter int W      = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic [TMR_NCH-1:0] irq
);
    localparam int NCH = TMR_NCH;

    logic [NCH-1:0][W-1:0] cnt, cmp;
    logic [NCH-1:0]        pend, en, cnt_wr, cmp_wr;

    cmp_timer_regs #(
        .W(W), .ADDR_W(ADDR_W), .NCH(NCH), .PEND_LSB(TMR_PEND_LSB)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .sel_i(bus_sel), .we_i(bus_we),
        .addr_i(bus_addr), .wdata_i(bus_wdata), .cnt_i(cnt), .cmp_i(cmp),
        .pend_i(pend), .en_o(en), .cnt_wr_o(cnt_wr), .cmp_wr_o(cmp_wr),
        .rdata_o(bus_rdata)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        cmp_timer_chan #(.W(W)) u_ch (
            .clk(clk), .rst_n(rst_n), .en_i(en[g]),
            .cnt_wr_i(cnt_wr[g]), .cmp_wr_i(cmp_wr[g]), .wdata_i(bus_wdata),
            .cnt_o(cnt[g]), .cmp_o(cmp[g]), .pend_o(pend[g]), .irq_o(irq[g])
        );
    end
endmodule

// File: rtl/cmp_timer_pair_chk.sv
module cmp_timer_pair_chk #(
    parameter int W   = 32,
    parameter int NCH = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [W-1:0]          wdata,
    input logic [NCH-1:0][W-1:0] cnt,
    input logic [NCH-1:0][W-1:0] cmp,
    input logic [NCH-1:0]        en,
    input logic [NCH-1:0]        pend,
    input logic [NCH-1:0]        irq,
    input logic [NCH-1:0]        cnt_wr,
    input logic [NCH-1:0]        cmp_wr
);
    for (genvar g = 0; g < NCH; g++) begin : g_a
        assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !cnt_wr[g] |=> cnt[g] == $past(cnt[g]) + W'(1));
        assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_wr[g] |=> cnt[g] == $past(wdata));
        assert_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend[g]) |-> (cnt[g] == cmp[g]) && $past(en[g]));
        assert_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
            cmp_wr[g] |=> !pend[g]);
        assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            pend[g] && !cmp_wr[g] |=> pend[g]);
        assert_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !en[g] |-> !irq[g]);
    end
endmodule

bind cmp_timer_pair cmp_timer_pair_chk #(.W(W), .NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .wdata(bus_wdata), .cnt(cnt), .cmp(cmp),
    .en(en), .pend(pend), .irq(irq), .cnt_wr(cnt_wr), .cmp_wr(cmp_wr)
);

// File: tb/cmp_timer_pair_test.sv
module cmp_timer_pair_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;
    int checks = 0, failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_timer_pair uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    function automatic logic [4:0] cmp_a(int ch); return 5'(4 + 8*ch); endfunction
    function automatic logic [4:0] cnt_a(int ch); return 5'(8 + 8*ch); endfunction

    task automatic pend_of(int ch, output logic [31:0] p);
        logic [31:0] v;
        rd(5'h00, v);
        p = (v >> (16 + ch)) & 32'd1;
    endtask

    // arm channel ch with count=s and compare=s+d, check match timing, then acknowledge
    task automatic arm(int ch, logic [31:0] s, int d, logic en);
        logic [31:0] v, c, tgt;
        string tag;
        tgt = s + 32'(d);
        tag = (tgt < s) ? "R6" : "R5";
        wr(cnt_a(ch), s);
        wr(cmp_a(ch), tgt);
        repeat (d - 2) @(negedge clk);
        pend_of(ch, v);  chk({tag, " no early match"}, v, 32'd0);
        @(negedge clk);
        rd(cnt_a(ch), v); chk("R3 count at match", v, tgt);
        pend_of(ch, v);  chk({tag, " pending at match"}, v, 32'(en));
        chk("R8 irq at match", 32'(irq[ch]), 32'(en));
        pend_of(1 - ch, v); chk("R10 other channel idle", v, 32'd0);
        rd(cnt_a(ch), c);
        wr(cmp_a(ch), c);
        pend_of(ch, v);  chk("R7 ack clears", v, 32'd0);
        repeat (12) @(negedge clk);
        pend_of(ch, v);  chk("R7 no re-raise", v, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v, keep;
        repeat (3) @(negedge clk);
        rd(5'h00, v); chk("R9 ctl reset", v, 32'd0);
        rd(5'h04, v); chk("R9 cmp0 reset", v, 32'hFFFF_FFFF);
        rd(5'h0C, v); chk("R9 cmp1 reset", v, 32'hFFFF_FFFF);
        rd(5'h10, v); chk("R9 cnt1 reset", v, 32'd0);
        chk("R9 irq reset", 32'(irq), 32'd0);
        rst_n = 1'b1;
        wr(5'h00, 32'h0000_0003);          // one edge: count 1
        repeat (299) @(negedge clk);
        rd(5'h08, v); chk("R3 free run count0", v, 32'd300);
        rd(5'h10, v); chk("R3 free run count1", v, 32'd300);
        rd(5'h00, v); chk("R5 all-ones compare idle", v, 32'h0000_0003);
        wr(5'h00, 32'hFFFF_FFFF);
        rd(5'h00, v); chk("R2 ctl mask", v, 32'h0000_0003);
        wr(5'h08, 32'h0000_1234);
        rd(5'h08, v); chk("R4 load", v, 32'h0000_1234);
        repeat (5) @(negedge clk);
        rd(5'h08, v); chk("R4 resume", v, 32'h0000_1239);
        wr(5'h04, 32'h8000_0000);
        wr(5'h08, 32'h8000_0000);
        rd(5'h08, v); chk("R4 load equal", v, 32'h8000_0000);
        pend_of(0, v); chk("R5 load equal no match", v, 32'd0);
        for (int ch = 0; ch < 2; ch++)
            for (int d = 2; d <= 9; d++) begin
                arm(ch, 32'd0, d, 1'b1);
                arm(ch, 32'h7FFF_FFF0, d, 1'b1);
                arm(ch, 32'hFFFF_FFFC, d, 1'b1);
            end
        wr(5'h00, 32'h0000_0002);
        arm(0, 32'd40, 6, 1'b0);
        wr(5'h00, 32'h0000_0001);
        arm(1, 32'hFFFF_FFFE, 7, 1'b0);
        wr(5'h00, 32'h0000_0003);
        wr(5'h10, 32'd50);
        wr(5'h0C, 32'd55);
        repeat (4) @(negedge clk);
        pend_of(1, v); chk("R5 ch1 pending", v, 32'd1);
        wr(5'h00, 32'h0000_0001);
        pend_of(1, v); chk("R8 pending kept when masked", v, 32'd1);
        chk("R8 irq masked", 32'(irq[1]), 32'd0);
        pend_of(0, v); chk("R10 ch0 unaffected", v, 32'd0);
        wr(5'h00, 32'h0000_0003);
        chk("R8 irq unmasked", 32'(irq[1]), 32'd1);
        rd(5'h10, v); wr(5'h0C, v);
        pend_of(1, v); chk("R7 ack ch1", v, 32'd0);
        rd(5'h04, keep);
        wr(5'h14, 32'hFFFF_FFFF);
        wr(5'h05, 32'h0000_0000);
        rd(5'h14, v); chk("R1 unmapped reads zero", v, 32'd0);
        rd(5'h1C, v); chk("R1 unmapped high reads zero", v, 32'd0);
        rd(5'h01, v); chk("R1 misaligned reads zero", v, 32'd0);
        rd(5'h04, v); chk("R1 misaligned write ignored", v, keep);
        rd(5'h00, v); chk("R1 ctl untouched", v, 32'h0000_0003);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule